// File: doc/BRIEF.md
# Seven-Level Priority Interrupt Arbiter

This block chooses which of 36 device interrupt requests is serviced next. Each device is placed on one of seven priority levels by a per-level device mask, or on level 0, where it can never be served. On every cycle the block scans the levels from 1, the most urgent, to 7. A level whose in-service bit is set ends the scan. A level switched off is skipped. The first level with a pending assigned device yields a winner, which is the lowest-numbered device pending there.

A grant is registered and presented on a valid/ready output. The output carries the level, the device number, and that device's service address and parameter from a per-device table. At the same moment the level's in-service bit is set. A table flag per device chooses what happens to the device's latched request on grant: it is cleared automatically, or it stays set until software clears it. A dismiss pulse retires the most urgent in-service level. A configuration port moves devices between levels, switches levels off, and rewrites device parameters.

Requests are merged from three sources: latched pulses, an external request word that counts only while its attention input is high, and live condition flags that own a fixed set of bit positions.

Top module: `irq_prio_arbiter`

## Requirements
- R1: After reset, no grant is offered, `int_possible` is 0, and both `lvl_busy` and `lvl_off` are all zero. Every device sits on level 0.
- R2: A device on level 0 is never granted, even with its request pending.
- R3: Among devices pending on the winning level, the grant names the lowest device number. `lvl_busy`/`lvl_off` bit i belongs to level i+1.
- R4: The scan stops at the first in-service level. That level and every less urgent level are not granted, and `int_possible` reads 0 when nothing more urgent is pending.
- R5: A more urgent level is granted while a less urgent one is in service. A grant sets its level's in-service bit in the same cycle `gnt_valid` rises. Default table contents are address ADDR_BASE+device and parameter PARAM_BASE+device.
- R6: A dismiss pulse clears only the in-service bit of the most urgent in-service level.
- R7: A device whose table flag is 0 has its latched request cleared by its grant. A device whose flag is 1 (by default only device 12) keeps requesting until a `req_clr` pulse clears its bit.
- R8: A level whose `lvl_off` bit is set is skipped, and the scan goes on to less urgent levels.
- R9: With `cfg_op`=0 (assign), the devices in `cfg_devmask` join level `cfg_level` and leave every other level. Level 0 removes them from all levels.
- R10: `ext_word` contributes requests only while `ext_attn` is 1.
- R11: Device positions 22, 32 and 35 take their request only from `live_flags`. Latched and external requests at those positions are ignored.
- R12: With `cfg_op`=1, the parameter of device `cfg_dev` is replaced by `cfg_param`, and its address and flag are unchanged. With `cfg_op`=2, `lvl_off` is loaded from `cfg_lvloff`. `cfg_op`=3 does nothing.
- R13: A grant stays valid and unchanged until `gnt_ready`. Only one grant is outstanding. `int_possible` is 1 exactly when the scan finds a winner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_set | input | 36 | One-cycle pulses that latch device requests |
| req_clr | input | 36 | One-cycle pulses that clear latched requests |
| ext_word | input | 36 | External request word |
| ext_attn | input | 1 | Qualifies `ext_word` |
| live_flags | input | 36 | Live condition flags (only the reserved positions count) |
| cfg_valid | input | 1 | Configuration command strobe |
| cfg_op | input | 2 | 0 assign, 1 parameter write, 2 level-off write, 3 none |
| cfg_level | input | 3 | Target level for assign (0 to 7) |
| cfg_devmask | input | 36 | Devices to assign |
| cfg_dev | input | 6 | Device for parameter write |
| cfg_param | input | 24 | New parameter value |
| cfg_lvloff | input | 7 | New level-off bits |
| dismiss | input | 1 | Retire the most urgent in-service level |
| gnt_valid | output | 1 | Grant offered |
| gnt_ready | input | 1 | Grant accepted |
| gnt_level | output | 3 | Granted level (1 to 7) |
| gnt_dev | output | 6 | Granted device |
| gnt_addr | output | 11 | Service address of the device |
| gnt_param | output | 24 | Parameter of the device |
| int_possible | output | 1 | A grantable request exists |
| lvl_busy | output | 7 | In-service bits per level |
| lvl_off | output | 7 | Level-off bits per level |

## Verification
Several properties are checked on every clock. A device belongs to at most one level. A fresh grant has its level marked in service. A grant never comes from a switched-off level or from a device that is not pending on its level. A held grant does not change. A lone dismiss removes exactly one in-service bit, and an auto-cleared request is gone on the next cycle. Other behaviours appear only as outcomes of ordered events, and the directed scenarios cover them:

- the lowest device wins among several pending ones;
- scanning stops at an in-service level but still lets a more urgent level through;
- manual requests return after a dismiss;
- the attention gating and the reserved flag positions;
- a parameter rewrite appears in the next grant.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
   typedef enum logic [1:0] {
      CFG_ASSIGN = 2'd0,
      CFG_PARAM  = 2'd1,
      CFG_LVLOFF = 2'd2,
      CFG_NONE   = 2'd3
   } cfg_op_e;
endpackage

// File: rtl/irq_req_merge.sv
module irq_req_merge #(
   parameter int          NUM_DEV  = 36,
   parameter logic [35:0] FLAG_POS = 36'h9_0040_0000
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_DEV-1:0] req_set,
   input  logic [NUM_DEV-1:0] req_clr,
   input  logic [NUM_DEV-1:0] take_clr,
   input  logic [NUM_DEV-1:0] ext_word,
   input  logic               ext_attn,
   input  logic [NUM_DEV-1:0] live_flags,
   output logic [NUM_DEV-1:0] eff_req
);
   localparam logic [NUM_DEV-1:0] FMASK = FLAG_POS[NUM_DEV-1:0];

   logic [NUM_DEV-1:0] latched_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) latched_q <= '0;
      else        latched_q <= (latched_q & ~req_clr & ~take_clr) | req_set;
   end

   always_comb begin
      eff_req = ((latched_q | (ext_attn ? ext_word : '0)) & ~FMASK)
              | (live_flags & FMASK);
   end

   assert_auto_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((take_clr != '0) && ((take_clr & req_set) == '0))
      |=> ((latched_q & $past(take_clr)) == '0));
endmodule

// File: rtl/irq_level_map.sv
module irq_level_map #(
   parameter int NUM_DEV = 36,
   parameter int NUM_LVL = 7,
   localparam int LVL_W  = $clog2(NUM_LVL + 1)
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            assign_en,
   input  logic [LVL_W-1:0]                assign_lvl,
   input  logic [NUM_DEV-1:0]              assign_mask,
   input  logic                            off_en,
   input  logic [NUM_LVL-1:0]              off_val,
   output logic [NUM_LVL-1:0][NUM_DEV-1:0] lvl_masks,
   output logic [NUM_LVL-1:0]              lvl_off
);
   for (genvar i = 0; i < NUM_LVL; i++) begin : g_lvl
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) lvl_masks[i] <= '0;
         else if (assign_en) begin
            if (assign_lvl == LVL_W'(i + 1)) lvl_masks[i] <= lvl_masks[i] | assign_mask;
            else                             lvl_masks[i] <= lvl_masks[i] & ~assign_mask;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      lvl_off <= '0;
      else if (off_en) lvl_off <= off_val;
   end

   for (genvar d = 0; d < NUM_DEV; d++) begin : g_chk
      logic [NUM_LVL-1:0] col;
      for (genvar i = 0; i < NUM_LVL; i++) begin : g_col
         assign col[i] = lvl_masks[i][d];
      end
      assert_one_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
         $onehot0(col));
   end
endmodule

// File: rtl/irq_level_scan.sv
module irq_level_scan #(
   parameter int NUM_DEV = 36,
   parameter int NUM_LVL = 7,
   localparam int LVL_W  = $clog2(NUM_LVL + 1),
   localparam int DEV_W  = $clog2(NUM_DEV)
) (
   input  logic [NUM_DEV-1:0]              eff_req,
   input  logic [NUM_LVL-1:0][NUM_DEV-1:0] lvl_masks,
   input  logic [NUM_LVL-1:0]              lvl_busy,
   input  logic [NUM_LVL-1:0]              lvl_off,
   output logic                            hit,
   output logic [LVL_W-1:0]                win_lvl,
   output logic [DEV_W-1:0]                win_dev
);
   logic [NUM_DEV-1:0] sel;
   logic               stop;

   always_comb begin
      hit     = 1'b0;
      stop    = 1'b0;
      win_lvl = '0;
      sel     = '0;
      for (int i = 0; i < NUM_LVL; i++) begin
         if (!hit && !stop) begin
            if (lvl_busy[i]) stop = 1'b1;
            else if (!lvl_off[i] && ((eff_req & lvl_masks[i]) != '0)) begin
               hit     = 1'b1;
               win_lvl = LVL_W'(i + 1);
               sel     = eff_req & lvl_masks[i];
            end
         end
      end
      win_dev = '0;
      for (int d = NUM_DEV - 1; d >= 0; d--) begin
         if (sel[d]) win_dev = DEV_W'(d);
      end
   end
endmodule

// File: rtl/irq_dev_table.sv
module irq_dev_table #(
   parameter int          NUM_DEV    = 36,
   parameter int          ADDR_W     = 11,
   parameter int          PARAM_W    = 24,
   parameter int          ADDR_BASE  = 'h100,
   parameter int          PARAM_BASE = 'h40,
   parameter logic [35:0] MANUAL_DEF = 36'h0_0000_1000,
   localparam int DEV_W = $clog2(NUM_DEV)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [DEV_W-1:0]   wr_dev,
   input  logic [PARAM_W-1:0] wr_param,
   input  logic [DEV_W-1:0]   rd_dev,
   output logic               rd_flag,
   output logic [ADDR_W-1:0]  rd_addr,
   output logic [PARAM_W-1:0] rd_param
);
   logic [NUM_DEV-1:0]              flag_q;
   logic [NUM_DEV-1:0][ADDR_W-1:0]  addr_q;
   logic [NUM_DEV-1:0][PARAM_W-1:0] param_q;

   for (genvar d = 0; d < NUM_DEV; d++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            flag_q[d]  <= MANUAL_DEF[d];
            addr_q[d]  <= ADDR_W'(ADDR_BASE + d);
            param_q[d] <= PARAM_W'(PARAM_BASE + d);
         end else if (wr_en && (wr_dev == DEV_W'(d))) begin
            param_q[d] <= wr_param;
         end
      end
   end

   assign rd_flag  = flag_q[rd_dev];
   assign rd_addr  = addr_q[rd_dev];
   assign rd_param = param_q[rd_dev];
endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
   import irq_arb_pkg::*;
#(
   parameter int          NUM_DEV    = 36,
   parameter int          NUM_LVL    = 7,
   parameter int          ADDR_W     = 11,
   parameter int          PARAM_W    = 24,
   parameter int          ADDR_BASE  = 'h100,
   parameter int          PARAM_BASE = 'h40,
   parameter logic [35:0] MANUAL_DEF = 36'h0_0000_1000,
   parameter logic [35:0] FLAG_POS   = 36'h9_0040_0000,
   localparam int LVL_W = $clog2(NUM_LVL + 1),
   localparam int DEV_W = $clog2(NUM_DEV)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_DEV-1:0] req_set,
   input  logic [NUM_DEV-1:0] req_clr,
   input  logic [NUM_DEV-1:0] ext_word,
   input  logic               ext_attn,
   input  logic [NUM_DEV-1:0] live_flags,
   input  logic               cfg_valid,
   input  logic [1:0]         cfg_op,
   input  logic [LVL_W-1:0]   cfg_level,
   input  logic [NUM_DEV-1:0] cfg_devmask,
   input  logic [DEV_W-1:0]   cfg_dev,
   input  logic [PARAM_W-1:0] cfg_param,
   input  logic [NUM_LVL-1:0] cfg_lvloff,
   input  logic               dismiss,
   output logic               gnt_valid,
   input  logic               gnt_ready,
   output logic [LVL_W-1:0]   gnt_level,
   output logic [DEV_W-1:0]   gnt_dev,
   output logic [ADDR_W-1:0]  gnt_addr,
   output logic [PARAM_W-1:0] gnt_param,
   output logic               int_possible,
   output logic [NUM_LVL-1:0] lvl_busy,
   output logic [NUM_LVL-1:0] lvl_off
);
   if (NUM_DEV < 2 || NUM_DEV > 36) begin : g_bad_dev
      $error("NUM_DEV must lie in 2..36");
   end
   if (NUM_LVL < 1) begin : g_bad_lvl
      $error("NUM_LVL must be at least 1");
   end

   cfg_op_e                         op;
   logic [NUM_DEV-1:0]              eff_req, take_clr;
   logic [NUM_LVL-1:0][NUM_DEV-1:0] lvl_masks;
   logic                            hit, grant_fire, rd_flag;
   logic [LVL_W-1:0]                win_lvl;
   logic [DEV_W-1:0]                win_dev;
   logic [ADDR_W-1:0]               rd_addr;
   logic [PARAM_W-1:0]              rd_param;
   logic [NUM_LVL-1:0]              dis_vec, set_vec;

   assign op         = cfg_op_e'(cfg_op);
   assign grant_fire = hit && !gnt_valid;
   assign take_clr   = (grant_fire && !rd_flag) ? (NUM_DEV'(1) << win_dev) : '0;

   irq_req_merge #(.NUM_DEV(NUM_DEV), .FLAG_POS(FLAG_POS)) u_merge (
      .clk, .rst_n, .req_set, .req_clr, .take_clr, .ext_word, .ext_attn,
      .live_flags, .eff_req);

   irq_level_map #(.NUM_DEV(NUM_DEV), .NUM_LVL(NUM_LVL)) u_map (
      .clk, .rst_n,
      .assign_en  (cfg_valid && op == CFG_ASSIGN),
      .assign_lvl (cfg_level),
      .assign_mask(cfg_devmask),
      .off_en     (cfg_valid && op == CFG_LVLOFF),
      .off_val    (cfg_lvloff),
      .lvl_masks, .lvl_off);

   irq_level_scan #(.NUM_DEV(NUM_DEV), .NUM_LVL(NUM_LVL)) u_scan (
      .eff_req, .lvl_masks, .lvl_busy, .lvl_off, .hit, .win_lvl, .win_dev);

   irq_dev_table #(.NUM_DEV(NUM_DEV), .ADDR_W(ADDR_W), .PARAM_W(PARAM_W),
      .ADDR_BASE(ADDR_BASE), .PARAM_BASE(PARAM_BASE), .MANUAL_DEF(MANUAL_DEF)) u_tab (
      .clk, .rst_n,
      .wr_en   (cfg_valid && op == CFG_PARAM),
      .wr_dev  (cfg_dev),
      .wr_param(cfg_param),
      .rd_dev  (win_dev),
      .rd_flag, .rd_addr, .rd_param);

   always_comb begin
      dis_vec = '0;
      for (int i = NUM_LVL - 1; i >= 0; i--) begin
         if (lvl_busy[i]) begin
            dis_vec    = '0;
            dis_vec[i] = 1'b1;
         end
      end
      set_vec = '0;
      for (int i = 0; i < NUM_LVL; i++) begin
         if (grant_fire && win_lvl == LVL_W'(i + 1)) set_vec[i] = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_busy  <= '0;
         gnt_valid <= 1'b0;
         gnt_level <= '0;
         gnt_dev   <= '0;
         gnt_addr  <= '0;
         gnt_param <= '0;
      end else begin
         lvl_busy <= (lvl_busy & ~(dismiss ? dis_vec : '0)) | set_vec;
         if (grant_fire) begin
            gnt_valid <= 1'b1;
            gnt_level <= win_lvl;
            gnt_dev   <= win_dev;
            gnt_addr  <= rd_addr;
            gnt_param <= rd_param;
         end else if (gnt_ready) begin
            gnt_valid <= 1'b0;
         end
      end
   end

   assign int_possible = hit;

   assert_busy_on_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gnt_valid) |-> lvl_busy[gnt_level - 1'b1]);

   assert_grant_held_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_valid && !gnt_ready) |=> (gnt_valid && $stable(gnt_dev) && $stable(gnt_param)));

   assert_dismiss_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (dismiss && !grant_fire && (lvl_busy != '0))
      |=> ($countones(lvl_busy) == $countones($past(lvl_busy)) - 1));

   assert_grant_not_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
      grant_fire |-> !lvl_off[win_lvl - 1'b1]);

   assert_win_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
      grant_fire |-> (eff_req[win_dev] && lvl_masks[win_lvl - 1'b1][win_dev]));
endmodule

// File: tb/sim_irq_prio_arbiter.sv
module sim_irq_prio_arbiter;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [35:0] req_set = '0, req_clr = '0, ext_word = '0, live_flags = '0, cfg_devmask = '0;
   logic        ext_attn = 1'b0, cfg_valid = 1'b0, dismiss = 1'b0, gnt_ready = 1'b0;
   logic [1:0]  cfg_op = 2'd3;
   logic [2:0]  cfg_level = '0;
   logic [5:0]  cfg_dev = '0;
   logic [23:0] cfg_param = '0;
   logic [6:0]  cfg_lvloff = '0;
   logic        gnt_valid, int_possible;
   logic [2:0]  gnt_level;
   logic [5:0]  gnt_dev;
   logic [10:0] gnt_addr;
   logic [23:0] gnt_param;
   logic [6:0]  lvl_busy, lvl_off;
   int          checks = 0, errors = 0;

   always #2 clk = ~clk;

   irq_prio_arbiter u0 (
      .clk, .rst_n, .req_set, .req_clr, .ext_word, .ext_attn, .live_flags,
      .cfg_valid, .cfg_op, .cfg_level, .cfg_devmask, .cfg_dev, .cfg_param,
      .cfg_lvloff, .dismiss, .gnt_valid, .gnt_ready, .gnt_level, .gnt_dev,
      .gnt_addr, .gnt_param, .int_possible, .lvl_busy, .lvl_off);

   function automatic logic [35:0] bit_of(input int d);
      return 36'(1) << d;
   endfunction

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic exp_gnt(input string tag, input int lvl, input int dev, input logic [23:0] prm);
      chk({tag, " valid"}, 64'(gnt_valid), 64'd1);
      chk({tag, " level"}, 64'(gnt_level), 64'(lvl));
      chk({tag, " dev"}, 64'(gnt_dev), 64'(dev));
      chk({tag, " addr"}, 64'(gnt_addr), 64'('h100 + dev));
      chk({tag, " param"}, 64'(gnt_param), 64'(prm));
   endtask

   task automatic exp_none(input string tag);
      chk({tag, " no grant"}, 64'(gnt_valid), 64'd0);
      chk({tag, " int_possible"}, 64'(int_possible), 64'd0);
   endtask

   task automatic pulse_req(input logic [35:0] m);
      req_set = m; @(negedge clk); req_set = '0;
   endtask

   task automatic cfg_assign(input int lvl, input logic [35:0] m);
      cfg_valid = 1; cfg_op = 2'd0; cfg_level = 3'(lvl); cfg_devmask = m;
      @(negedge clk); cfg_valid = 0; cfg_op = 2'd3;
   endtask

   task automatic cfg_off(input logic [6:0] v);
      cfg_valid = 1; cfg_op = 2'd2; cfg_lvloff = v;
      @(negedge clk); cfg_valid = 0; cfg_op = 2'd3;
   endtask

   task automatic cfg_prm(input int dev, input logic [23:0] p);
      cfg_valid = 1; cfg_op = 2'd1; cfg_dev = 6'(dev); cfg_param = p;
      @(negedge clk); cfg_valid = 0; cfg_op = 2'd3;
   endtask

   task automatic ack();
      gnt_ready = 1; @(negedge clk); gnt_ready = 0;
   endtask

   task automatic do_dismiss();
      dismiss = 1; @(negedge clk); dismiss = 0;
   endtask

   task automatic t_reset();
      chk("R1 gnt_valid", 64'(gnt_valid), 0);
      chk("R1 int_possible", 64'(int_possible), 0);
      chk("R1 lvl_busy", 64'(lvl_busy), 0);
      chk("R1 lvl_off", 64'(lvl_off), 0);
   endtask

   task automatic t_unassigned();
      pulse_req(bit_of(5) | bit_of(9));
      @(negedge clk); @(negedge clk);
      exp_none("R2 level0");
   endtask

   task automatic t_lowest_and_block();
      cfg_assign(3, bit_of(5) | bit_of(9));
      @(negedge clk);
      exp_gnt("R3 lowest", 3, 5, 24'h40 + 5);
      chk("R5 busy lvl3", 64'(lvl_busy), 64'h04);
      @(negedge clk);
      exp_gnt("R13 held", 3, 5, 24'h40 + 5);
      ack();
      exp_none("R4 blocked");
   endtask

   task automatic t_preempt_dismiss();
      cfg_assign(1, bit_of(2));
      pulse_req(bit_of(2));
      @(negedge clk);
      exp_gnt("R5 preempt", 1, 2, 24'h40 + 2);
      chk("R5 busy both", 64'(lvl_busy), 64'h05);
      ack();
      do_dismiss();
      chk("R6 dismiss top", 64'(lvl_busy), 64'h04);
      @(negedge clk);
      exp_none("R4 still blocked");
      do_dismiss();
      chk("R6 all clear", 64'(lvl_busy), 64'h00);
      @(negedge clk);
      exp_gnt("R3 next", 3, 9, 24'h40 + 9);
      ack(); do_dismiss();
      @(negedge clk); @(negedge clk);
      exp_none("R7 auto cleared");
   endtask

   task automatic t_manual();
      cfg_assign(2, bit_of(12));
      pulse_req(bit_of(12));
      @(negedge clk);
      exp_gnt("R7 manual first", 2, 12, 24'h40 + 12);
      ack(); do_dismiss();
      @(negedge clk);
      exp_gnt("R7 manual again", 2, 12, 24'h40 + 12);
      ack();
      req_clr = bit_of(12); dismiss = 1;
      @(negedge clk);
      req_clr = '0; dismiss = 0;
      @(negedge clk); @(negedge clk);
      exp_none("R7 after clear");
   endtask

   task automatic t_level_off();
      cfg_assign(4, bit_of(20));
      cfg_assign(5, bit_of(21));
      cfg_off(7'b0001000);
      chk("R12 lvl_off write", 64'(lvl_off), 64'h08);
      pulse_req(bit_of(20) | bit_of(21));
      @(negedge clk);
      exp_gnt("R8 skip off", 5, 21, 24'h40 + 21);
      ack(); do_dismiss();
      cfg_off(7'b0);
      @(negedge clk);
      exp_gnt("R8 back on", 4, 20, 24'h40 + 20);
      ack(); do_dismiss();
   endtask

   task automatic t_reassign();
      cfg_assign(6, bit_of(20));
      pulse_req(bit_of(20));
      @(negedge clk);
      exp_gnt("R9 moved", 6, 20, 24'h40 + 20);
      ack(); do_dismiss();
   endtask

   task automatic t_ext_flags();
      cfg_assign(7, bit_of(30) | bit_of(22));
      ext_word = bit_of(30) | bit_of(22);
      @(negedge clk); @(negedge clk);
      exp_none("R10 no attn");
      ext_attn = 1;
      @(negedge clk);
      exp_gnt("R11 ext masked", 7, 30, 24'h40 + 30);
      ext_attn = 0;
      ack(); do_dismiss();
      @(negedge clk);
      exp_none("R10 not latched");
      live_flags = bit_of(22);
      @(negedge clk);
      exp_gnt("R11 live flag", 7, 22, 24'h40 + 22);
      live_flags = '0;
      ack(); do_dismiss();
   endtask

   task automatic t_param();
      cfg_prm(30, 24'hABCDE);
      ext_word = bit_of(30); ext_attn = 1;
      @(negedge clk);
      exp_gnt("R12 param", 7, 30, 24'hABCDE);
      ext_attn = 0;
      ack(); do_dismiss();
      @(negedge clk);
      exp_none("R13 idle end");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_unassigned();
      t_lowest_and_block();
      t_preempt_dismiss();
      t_manual();
      t_level_off();
      t_reassign();
      t_ext_flags();
      t_param();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog all actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule